// File: doc/BRIEF.md
# Transition-Coded Serial Word Sender

This block takes one parallel word at a time from a local valid/ready interface and sends it over a two-wire channel, one bit per clock edge, least-significant bit first. Each bit is carried by a single transition. The data wire always shows the value of the current bit. The strobe wire toggles only when the new bit has the same value as the one before it. As a result, data XOR strobe inverts on every bit, and exactly one wire changes for each bit sent.

Flow control works per word, not per bit. When the last bit of a word has gone out, the sender waits for the receiver's acknowledge. The acknowledge is a two-phase toggle from another clock domain, and it enters through a two-flop synchronizer. A word counts as accepted once the synchronized acknowledge level differs from the phase the sender last recorded. After reset both wires are low and the recorded phase is zero, so the first word can leave at once.

The controller has three states:
- `ST_IDLE`: ready is high.
- `ST_SHIFT`: the remaining bits are going out.
- `ST_WAIT`: the controller is waiting for the acknowledge toggle.

It has four transitions:
- `take`: from IDLE to SHIFT, or straight to WAIT for a one-bit word.
- `last_bit`: from SHIFT to WAIT.
- `acked`: from WAIT to IDLE.
- `reset`: from any state to IDLE.

Top module: `ledr_word_tx`

## Requirements
- R1: While reset is asserted and directly after it, `line_data` and `line_strobe` are 0 and `in_ready` is 1.
- R2: On every clock edge that sends a bit, exactly one of `line_data` and `line_strobe` changes. On any other edge, neither changes.
- R3: Bits leave least-significant first. Bit k of the word appears on `line_data` after the k-th edge following the capture edge, where the capture edge itself counts as edge 0.
- R4: `line_strobe` toggles on a bit edge exactly when the new bit equals the previous value of `line_data`.
- R5: A word is captured on an edge where `in_valid` and `in_ready` are both 1. Its first bit goes out on that same edge, and `in_ready` is 0 after it.
- R6: After the last bit, `in_ready` stays 0 until the synchronized acknowledge differs from the recorded phase. On that edge the phase is updated and `in_ready` returns to 1.
- R7: `ack_toggle` passes through two flip-flops. A change that settles before edge e is acted on at edge e+2, so `in_ready` goes high after that edge.
- R8: While `in_ready` is 0, `in_valid` and `in_word` have no effect on either wire.
- R9: An acknowledge toggle that arrives while bits are still going out is kept. It releases the sender on the first waiting edge.
- R10: The acknowledge works in both directions: a rise and a fall each accept one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sender clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_word | input | WIDTH | The word offered |
| in_ready | output | 1 | The sender can take a word |
| ack_toggle | input | 1 | Two-phase acknowledge from the receiver, asynchronous |
| line_data | output | 1 | Channel data wire |
| line_strobe | output | 1 | Channel strobe wire |

## Verification
The bench goes after words whose neighbouring bits are equal (all zeros, all ones) and words whose bits alternate. If the strobe rule were inverted, both wires would move together or neither would move, and the reference comparison would flag it. It also toggles the acknowledge early, during shifting, which would hang a design that only looked at edges seen while waiting. It sends the acknowledge in both polarities, which a design that waited for a rising edge would miss. Finally, it holds `in_valid` high during the wait, so a design that captured a word while busy would show extra wire transitions.

// File: rtl/ledr_tx_pkg.sv
package ledr_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WAIT  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ledr_ack_sync.sv
module ledr_ack_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async,
    output logic ack_sync
);
    logic stage1, stage2;
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= ack_async;
            stage2 <= stage1;
        end
    end

    assign ack_sync = stage2;

    // age of the pipeline since reset, for the latency check only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    a_r7_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (ack_sync == $past(ack_async, 2)));
endmodule

// File: rtl/ledr_encoder.sv
module ledr_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_val,
    output logic wire_data,
    output logic wire_strobe
);
    logic data_q, strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else if (bit_valid) begin
            data_q <= bit_val;
            if (bit_val == data_q)
                strobe_q <= ~strobe_q;
        end
    end

    assign wire_data   = data_q;
    assign wire_strobe = strobe_q;

    a_r2_one_wire: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> ($countones({wire_data, wire_strobe} ^ $past({wire_data, wire_strobe})) == 1));

    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(wire_data) && $stable(wire_strobe)));
endmodule

// File: rtl/ledr_tx_ctrl.sv
module ledr_tx_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             in_ready,
    input  logic             ack_sync,
    output logic             bit_valid,
    output logic             bit_val
);
    import ledr_tx_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] REST = CW'(WIDTH - 1);

    tx_state_e        state, state_nx;
    logic [WIDTH-1:0] shreg;
    logic [CW-1:0]    remain;
    logic             ack_phase;
    logic             take, acked, last_bit;

    assign take     = (state == ST_IDLE) && in_valid;
    assign acked    = (state == ST_WAIT) && (ack_sync != ack_phase);
    assign last_bit = (state == ST_SHIFT) && (remain == CW'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take)     state_nx = (WIDTH > 1) ? ST_SHIFT : ST_WAIT;
            ST_SHIFT: if (last_bit) state_nx = ST_WAIT;
            ST_WAIT:  if (acked)    state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            remain    <= '0;
            ack_phase <= 1'b0;
        end else begin
            if (take) begin
                shreg  <= in_word >> 1;
                remain <= REST;
            end else if (state == ST_SHIFT) begin
                shreg  <= shreg >> 1;
                remain <= remain - CW'(1);
            end
            if (acked)
                ack_phase <= ack_sync;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        bit_valid = 1'b0;
        bit_val   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_ready  = 1'b1;
                bit_valid = in_valid;
                bit_val   = in_word[0];
            end
            ST_SHIFT: begin
                bit_valid = 1'b1;
                bit_val   = shreg[0];
            end
            ST_WAIT: ;
            default: ;
        endcase
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && ack_sync == ack_phase) |=> (state == ST_WAIT));

    a_r3_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (remain != '0));
endmodule

// File: rtl/ledr_word_tx.sv
module ledr_word_tx #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    output logic             in_ready,
    input  logic             ack_toggle,
    output logic             line_data,
    output logic             line_strobe
);
    logic ack_sync, bit_valid, bit_val;

    ledr_ack_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_async (ack_toggle),
        .ack_sync  (ack_sync)
    );

    ledr_tx_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_ready  (in_ready),
        .ack_sync  (ack_sync),
        .bit_valid (bit_valid),
        .bit_val   (bit_val)
    );

    ledr_encoder u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .wire_data   (line_data),
        .wire_strobe (line_strobe)
    );
endmodule

// File: tb/test_ledr_word_tx.sv
module test_ledr_word_tx;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_word = '0;
    logic         ack_toggle = 1'b0;
    logic         in_ready, line_data, line_strobe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ledr_word_tx #(.WIDTH(W)) i_ledr_word_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .ack_toggle(ack_toggle),
        .line_data(line_data), .line_strobe(line_strobe)
    );

    // behavioural reference
    int  m_mode = 0;          // 0 idle, 1 sending, 2 waiting
    bit  m_bits[$];
    bit  m_data = 0, m_strobe = 0, m_phase = 0, m_s1 = 0, m_s2 = 0;
    bit  m_sent = 0;

    task automatic emit(input bit b);
        if (b == m_data) m_strobe = ~m_strobe;
        m_data = b;
        m_sent = 1;
    endtask

    always @(posedge clk) begin
        m_sent = 0;
        if (!rst_n) begin
            m_mode = 0; m_bits.delete(); m_data = 0; m_strobe = 0;
            m_phase = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            case (m_mode)
                0: if (in_valid) begin
                    for (int i = 1; i < W; i++) m_bits.push_back(in_word[i]);
                    emit(in_word[0]);
                    m_mode = (m_bits.size() > 0) ? 1 : 2;
                end
                1: begin
                    emit(m_bits.pop_front());
                    if (m_bits.size() == 0) m_mode = 2;
                end
                default: if (m_s2 != m_phase) begin
                    m_phase = m_s2;
                    m_mode = 0;
                end
            endcase
            m_s2 = m_s1;
            m_s1 = ack_toggle;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    bit prev_d = 0, prev_s = 0;
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(line_data == m_data, "R3", line_data, m_data);
            check(line_strobe == m_strobe, "R4", line_strobe, m_strobe);
            check(in_ready == (m_mode == 0), "R6", in_ready, m_mode == 0);
            // R2: one wire moves per bit, none otherwise
            check($countones({line_data ^ prev_d, line_strobe ^ prev_s}) == (m_sent ? 1 : 0), "R2",
                  $countones({line_data ^ prev_d, line_strobe ^ prev_s}), m_sent ? 1 : 0);
        end
        prev_d = line_data;
        prev_s = line_strobe;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [W-1:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        // R5: ready drops after the capture edge
        check(in_ready == 1'b0, "R5", in_ready, 0);
    endtask

    task automatic wait_bits;
        repeat (W - 1) @(negedge clk);
    endtask

    task automatic ack_and_time;
        int n;
        ack_toggle = ~ack_toggle;
        n = 0;
        while (!in_ready && n < 10) begin
            @(negedge clk);
            n++;
        end
        // R7: toggle settles before edge e, acted on at e+2, seen at the 3rd negedge
        check(n == 3, "R7", n, 3);
    endtask

    initial begin
        logic sd, ss;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(line_data == 0 && line_strobe == 0 && in_ready == 1, "R1",
              {line_data, line_strobe, in_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_data == 0 && line_strobe == 0 && in_ready == 1, "R1",
              {line_data, line_strobe, in_ready}, 3'b001);

        send(8'hA5); wait_bits(); @(negedge clk);
        // R3: last bit of A5 (bit 7 = 1) on data wire
        check(line_data == 1'b1, "R3", line_data, 1);
        ack_and_time();                       // R10: rising toggle

        send(8'h00); wait_bits(); @(negedge clk);
        // R8: valid held while waiting, wires must not move
        in_valid = 1'b1; in_word = 8'h5A;
        sd = line_data; ss = line_strobe;
        repeat (5) @(negedge clk);
        check(line_data == sd && line_strobe == ss, "R8", {line_data, line_strobe}, {sd, ss});
        check(in_ready == 1'b0, "R6", in_ready, 0);
        in_valid = 1'b0;
        ack_and_time();                       // R10: falling toggle

        // R9: acknowledge toggled during shifting
        send(8'hFF);
        ack_toggle = ~ack_toggle;
        repeat (W + 4) @(negedge clk);
        check(in_ready == 1'b1, "R9", in_ready, 1);

        send(8'h01); wait_bits(); @(negedge clk); ack_and_time();
        send(8'h55); wait_bits(); @(negedge clk); ack_and_time();
        send(8'h3C); wait_bits(); @(negedge clk); ack_and_time();

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule